// File: doc/BRIEF.md
# Issue Queue with Register Wakeup

This block holds renamed instructions of an out-of-order core until their source operands become available. Each accepted instruction carries a sequence number, a class code, up to two source physical-register tags and up to one destination tag. A scoreboard with one bit per physical register records which values exist. An instruction whose source value already exists, or arrives in the same cycle, is marked ready when it is written into the queue. Otherwise the entry watches the completion broadcast until its tag appears.

An outside selector reads the per-entry ready vector and removes one entry per cycle by index. Recovery logic invalidates every younger entry with a squash sequence number. Instructions that must not run speculatively enter the queue with issue permission withheld, and an explicit schedule command releases them. The queue also reports its free-slot count and whether it is full. An insert attempted while the queue is full is dropped and recorded in a sticky overflow flag.

Top module: `issue_queue_wakeup`

## Requirements
- R1: The free count is DEPTH after reset. Each accepted insert lowers it by one, and each issued or squashed entry raises it by one. `full` is high exactly when the count is zero.
- R2: After reset no entry is valid, `ready_vec` is zero, and every scoreboard bit reads not-ready.
- R3: At insert, a used source that rename flags ready counts as ready. Otherwise its scoreboard bit decides: if the bit is set the source is ready at once, and if it is clear the entry waits for a broadcast of that tag. An unused source counts as ready.
- R4: An accepted insert with a used destination tag clears that tag's scoreboard bit, so later consumers of the tag wait.
- R5: A completion broadcast sets the tag's scoreboard bit, and every valid entry waiting on that tag marks the matching source ready in the next cycle.
- R6: A tag at or above NUM_INT_PREGS+NUM_FP_PREGS is never looked up, tracked or woken. Such a source counts as ready, and a broadcast of such a tag changes nothing.
- R7: A squash with sequence S invalidates each valid entry whose sequence number is greater than S in unsigned comparison, unless that entry issues in the same cycle. Each invalidated entry returns one free slot. An entry whose sequence number equals S survives.
- R8: Bit i of `ready_vec` is valid AND both sources ready AND issue permission held. A new entry is written into the lowest-index free slot. A broadcast in the same cycle as an insert is seen by the new entry. `issue_seq` and `issue_cls` show the contents of the slot that `issue_idx` selects, in the same cycle.
- R9: An entry inserted with `ins_nonspec` high is not ready until a schedule command carries its sequence number. A schedule command with a non-matching number has no effect.
- R10: An insert while `full` is high is dropped and leaves the free count unchanged. It sets `overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the new instruction |
| ins_cls | input | CLS_W | Class code of the new instruction |
| ins_nonspec | input | 1 | Withhold issue permission until scheduled |
| ins_src0_use | input | 1 | Source 0 is used |
| ins_src0_tag | input | TAG_W | Source 0 physical tag |
| ins_src0_rdy | input | 1 | Rename already marks source 0 ready |
| ins_src1_use | input | 1 | Source 1 is used |
| ins_src1_tag | input | TAG_W | Source 1 physical tag |
| ins_src1_rdy | input | 1 | Rename already marks source 1 ready |
| ins_dst_use | input | 1 | Destination is used |
| ins_dst_tag | input | TAG_W | Destination physical tag |
| wake_valid | input | 1 | Completion broadcast |
| wake_tag | input | TAG_W | Tag being completed |
| issue_valid | input | 1 | Remove the selected entry as issued |
| issue_idx | input | IDX_W | Slot to issue |
| sched_valid | input | 1 | Grant issue permission |
| sched_seq | input | SEQ_W | Sequence number to grant |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| ready_vec | output | DEPTH | Per-slot ready to issue |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot |
| overflow | output | 1 | Sticky insert-while-full flag |
| issue_seq | output | SEQ_W | Sequence number in slot issue_idx |
| issue_cls | output | CLS_W | Class code in slot issue_idx |

## Verification
A stale or wrong scoreboard bit appears in `ready_vec` in the cycle after the insert that consults it. The bit is either set too early or never set, and the second case shows as a slot that stays low after its broadcast. A lost or doubled free-slot update shows in `free_cnt` after the next insert, issue or squash, and it also moves the slot that the next insert takes. A wrong squash bound or permission gate shows as a ready bit present or absent one cycle after the squash or schedule command. All of these appear within one or two cycles of the triggering stimulus.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEF_DEPTH   = 8;
  localparam int unsigned IQ_DEF_INT_REG = 16;
  localparam int unsigned IQ_DEF_FP_REG  = 16;
  localparam int unsigned IQ_DEF_TAG_W   = 6;
  localparam int unsigned IQ_DEF_SEQ_W   = 8;
  localparam int unsigned IQ_DEF_CLS_W   = 3;

  typedef enum logic {
    PERM_HELD    = 1'b0,
    PERM_GRANTED = 1'b1
  } perm_e;
endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int unsigned NPHYS = 32,
  parameter int unsigned TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [TAG_W-1:0] q0_tag,
  input  logic [TAG_W-1:0] q1_tag,
  output logic             q0_rdy,
  output logic             q1_rdy,
  output logic             set_hit
);
  localparam int unsigned IDX_W = (NPHYS > 1) ? $clog2(NPHYS) : 1;
  localparam logic [TAG_W:0] LIM = (TAG_W+1)'(NPHYS);

  logic [NPHYS-1:0] sb_q, sb_d;
  logic clr_in, set_in, q0_in, q1_in;

  assign clr_in  = ({1'b0, clr_tag} < LIM);
  assign set_in  = ({1'b0, set_tag} < LIM);
  assign q0_in   = ({1'b0, q0_tag} < LIM);
  assign q1_in   = ({1'b0, q1_tag} < LIM);
  assign set_hit = set_en & set_in;

  // out-of-range tags read as ready; a same-cycle broadcast is bypassed
  always_comb begin
    q0_rdy = 1'b1;
    q1_rdy = 1'b1;
    if (q0_in)
      q0_rdy = sb_q[q0_tag[IDX_W-1:0]] | (set_hit & (set_tag == q0_tag));
    if (q1_in)
      q1_rdy = sb_q[q1_tag[IDX_W-1:0]] | (set_hit & (set_tag == q1_tag));
  end

  always_comb begin
    sb_d = sb_q;
    if (set_hit)
      sb_d[set_tag[IDX_W-1:0]] = 1'b1;
    if (clr_en && clr_in)
      sb_d[clr_tag[IDX_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sb_q <= '0;
    else        sb_q <= sb_d;
  end

  p_wake_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !(clr_en && clr_in && clr_tag == set_tag))
      |=> sb_q[$past(set_tag[IDX_W-1:0])]);

  p_dst_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_in) |=> !sb_q[$past(clr_tag[IDX_W-1:0])]);
endmodule

// File: rtl/iq_slot.sv
module iq_slot
  import iq_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic [CLS_W-1:0] a_cls,
  input  logic             a_nonspec,
  input  logic [TAG_W-1:0] a_tag0,
  input  logic [TAG_W-1:0] a_tag1,
  input  logic             a_rdy0,
  input  logic             a_rdy1,
  input  logic             wake_en,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic             issue_hit,
  input  logic             squash_en,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic             sched_en,
  input  logic [SEQ_W-1:0] sched_seq,
  output logic             valid,
  output logic             ready,
  output logic             killed,
  output logic [SEQ_W-1:0] seq,
  output logic [CLS_W-1:0] cls
);
  logic             vld_q, vld_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [CLS_W-1:0] cls_q, cls_d;
  logic [TAG_W-1:0] t0_q, t0_d, t1_q, t1_d;
  logic             r0_q, r0_d, r1_q, r1_d;
  perm_e            perm_q, perm_d;
  logic             load_en;

  assign killed  = vld_q & ~issue_hit & squash_en & (seq_q > squash_seq);
  assign load_en = alloc | vld_q;

  always_comb begin
    vld_d  = vld_q;
    seq_d  = seq_q;
    cls_d  = cls_q;
    t0_d   = t0_q;
    t1_d   = t1_q;
    r0_d   = r0_q;
    r1_d   = r1_q;
    perm_d = perm_q;
    if (alloc) begin
      vld_d  = 1'b1;
      seq_d  = a_seq;
      cls_d  = a_cls;
      t0_d   = a_tag0;
      t1_d   = a_tag1;
      r0_d   = a_rdy0;
      r1_d   = a_rdy1;
      perm_d = a_nonspec ? PERM_HELD : PERM_GRANTED;
    end else if (vld_q) begin
      if (issue_hit || killed) vld_d = 1'b0;
      if (wake_en && wake_tag == t0_q) r0_d = 1'b1;
      if (wake_en && wake_tag == t1_q) r1_d = 1'b1;
      if (sched_en && sched_seq == seq_q) perm_d = PERM_GRANTED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      seq_q  <= seq_d;
      cls_q  <= cls_d;
      t0_q   <= t0_d;
      t1_q   <= t1_d;
      r0_q   <= r0_d;
      r1_q   <= r1_d;
      perm_q <= perm_d;
    end
  end

  assign valid = vld_q;
  assign ready = vld_q & r0_q & r1_q & (perm_q == PERM_GRANTED);
  assign seq   = seq_q;
  assign cls   = cls_q;

  p_squash_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    killed |=> !vld_q);

  p_alloc_free_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !vld_q);

  p_wake_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !alloc && wake_en && wake_tag == t0_q) |=> r0_q);
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0] busy,
  input  logic             req,
  output logic [DEPTH-1:0] grant
);
  logic [DEPTH:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_pick
    assign grant[g]  = req & ~busy[g] & ~seen[g];
    assign seen[g+1] = seen[g] | ~busy[g];
  end

  always_comb begin
    a_onehot_r8: assert ($onehot0(grant));
  end
endmodule

// File: rtl/issue_queue_wakeup.sv
module issue_queue_wakeup
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH         = IQ_DEF_DEPTH,
  parameter int unsigned NUM_INT_PREGS = IQ_DEF_INT_REG,
  parameter int unsigned NUM_FP_PREGS  = IQ_DEF_FP_REG,
  parameter int unsigned TAG_W         = IQ_DEF_TAG_W,
  parameter int unsigned SEQ_W         = IQ_DEF_SEQ_W,
  parameter int unsigned CLS_W         = IQ_DEF_CLS_W,
  localparam int unsigned IDX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [CLS_W-1:0] ins_cls,
  input  logic             ins_nonspec,
  input  logic             ins_src0_use,
  input  logic [TAG_W-1:0] ins_src0_tag,
  input  logic             ins_src0_rdy,
  input  logic             ins_src1_use,
  input  logic [TAG_W-1:0] ins_src1_tag,
  input  logic             ins_src1_rdy,
  input  logic             ins_dst_use,
  input  logic [TAG_W-1:0] ins_dst_tag,
  input  logic             wake_valid,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic             issue_valid,
  input  logic [IDX_W-1:0] issue_idx,
  input  logic             sched_valid,
  input  logic [SEQ_W-1:0] sched_seq,
  input  logic             squash_valid,
  input  logic [SEQ_W-1:0] squash_seq,
  output logic [DEPTH-1:0] ready_vec,
  output logic [CNT_W-1:0] free_cnt,
  output logic             full,
  output logic             overflow,
  output logic [SEQ_W-1:0] issue_seq,
  output logic [CLS_W-1:0] issue_cls
);
  localparam int unsigned NPHYS = NUM_INT_PREGS + NUM_FP_PREGS;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(DEPTH);

  logic             ins_acc;
  logic             sb_q0, sb_q1, wake_hit;
  logic             src0_ok, src1_ok;
  logic [DEPTH-1:0] valid_v, killed_v, grant_v, issue_v;
  logic [SEQ_W-1:0] seq_a [DEPTH];
  logic [CLS_W-1:0] cls_a [DEPTH];
  logic [CNT_W-1:0] free_q, free_d, kill_cnt;
  logic             iss_acc;
  logic             ovf_q, ovf_d;

  assign full    = (free_q == '0);
  assign ins_acc = ins_valid & ~full;

  iq_scoreboard #(.NPHYS(NPHYS), .TAG_W(TAG_W)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (ins_acc & ins_dst_use),
    .clr_tag (ins_dst_tag),
    .set_en  (wake_valid),
    .set_tag (wake_tag),
    .q0_tag  (ins_src0_tag),
    .q1_tag  (ins_src1_tag),
    .q0_rdy  (sb_q0),
    .q1_rdy  (sb_q1),
    .set_hit (wake_hit)
  );

  assign src0_ok = ~ins_src0_use | ins_src0_rdy | sb_q0;
  assign src1_ok = ~ins_src1_use | ins_src1_rdy | sb_q1;

  iq_alloc #(.DEPTH(DEPTH)) u_alloc (
    .busy  (valid_v),
    .req   (ins_acc),
    .grant (grant_v)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign issue_v[g] = issue_valid & (issue_idx == IDX_W'(g)) & valid_v[g];

    iq_slot #(.TAG_W(TAG_W), .SEQ_W(SEQ_W), .CLS_W(CLS_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (grant_v[g]),
      .a_seq      (ins_seq),
      .a_cls      (ins_cls),
      .a_nonspec  (ins_nonspec),
      .a_tag0     (ins_src0_tag),
      .a_tag1     (ins_src1_tag),
      .a_rdy0     (src0_ok),
      .a_rdy1     (src1_ok),
      .wake_en    (wake_hit),
      .wake_tag   (wake_tag),
      .issue_hit  (issue_v[g]),
      .squash_en  (squash_valid),
      .squash_seq (squash_seq),
      .sched_en   (sched_valid),
      .sched_seq  (sched_seq),
      .valid      (valid_v[g]),
      .ready      (ready_vec[g]),
      .killed     (killed_v[g]),
      .seq        (seq_a[g]),
      .cls        (cls_a[g])
    );
  end

  always_comb begin
    issue_seq = '0;
    issue_cls = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (issue_idx == IDX_W'(i)) begin
        issue_seq = seq_a[i];
        issue_cls = cls_a[i];
      end
    end
  end

  always_comb begin
    kill_cnt = '0;
    for (int i = 0; i < DEPTH; i++)
      kill_cnt = kill_cnt + CNT_W'(killed_v[i]);
  end

  assign iss_acc = |issue_v;

  always_comb begin
    free_d = free_q + kill_cnt + CNT_W'(iss_acc) - CNT_W'(ins_acc);
    ovf_d  = ovf_q | (ins_valid & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= CNT_RST;
      ovf_q  <= 1'b0;
    end else begin
      free_q <= free_d;
      ovf_q  <= ovf_d;
    end
  end

  assign free_cnt = free_q;
  assign overflow = ovf_q;

  p_free_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid_v) + int'(free_q)) == DEPTH);

  p_free_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    free_q <= CNT_RST);

  p_empty_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == CNT_RST) |-> (ready_vec == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && full) |=> overflow);

  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_valid) |-> (grant_v == '0));
endmodule

// File: tb/test_issue_queue_wakeup.sv
module test_issue_queue_wakeup;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned TAG_W = 5;
  localparam int unsigned SEQ_W = 8;
  localparam int unsigned CLS_W = 3;
  localparam int unsigned IDX_W = 2;
  localparam int unsigned CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic             ins_valid, ins_nonspec;
  logic [SEQ_W-1:0] ins_seq;
  logic [CLS_W-1:0] ins_cls;
  logic             ins_src0_use, ins_src0_rdy, ins_src1_use, ins_src1_rdy, ins_dst_use;
  logic [TAG_W-1:0] ins_src0_tag, ins_src1_tag, ins_dst_tag;
  logic             wake_valid;
  logic [TAG_W-1:0] wake_tag;
  logic             issue_valid;
  logic [IDX_W-1:0] issue_idx;
  logic             sched_valid, squash_valid;
  logic [SEQ_W-1:0] sched_seq, squash_seq;
  logic [DEPTH-1:0] ready_vec;
  logic [CNT_W-1:0] free_cnt;
  logic             full, overflow;
  logic [SEQ_W-1:0] issue_seq;
  logic [CLS_W-1:0] issue_cls;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [DEPTH-1:0] rdy;
    logic [CNT_W-1:0] fr;
    logic             fu;
    logic             ov;
    string            req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  issue_queue_wakeup #(
    .DEPTH(DEPTH), .NUM_INT_PREGS(8), .NUM_FP_PREGS(8),
    .TAG_W(TAG_W), .SEQ_W(SEQ_W), .CLS_W(CLS_W)
  ) i_issue_queue_wakeup (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_cls(ins_cls),
    .ins_nonspec(ins_nonspec),
    .ins_src0_use(ins_src0_use), .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
    .ins_src1_use(ins_src1_use), .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
    .ins_dst_use(ins_dst_use), .ins_dst_tag(ins_dst_tag),
    .wake_valid(wake_valid), .wake_tag(wake_tag),
    .issue_valid(issue_valid), .issue_idx(issue_idx),
    .sched_valid(sched_valid), .sched_seq(sched_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .ready_vec(ready_vec), .free_cnt(free_cnt), .full(full), .overflow(overflow),
    .issue_seq(issue_seq), .issue_cls(issue_cls)
  );

  // monitor: compare registered outputs half a cycle after each edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (ready_vec !== e.rdy || free_cnt !== e.fr || full !== e.fu || overflow !== e.ov) begin
        n_bad++;
        $display("FAIL %s: ready=%b free=%0d full=%b ovf=%b expected ready=%b free=%0d full=%b ovf=%b",
                 e.req, ready_vec, free_cnt, full, overflow, e.rdy, e.fr, e.fu, e.ov);
      end
    end
  end

  task automatic idle();
    ins_valid = 0; ins_seq = '0; ins_cls = '0; ins_nonspec = 0;
    ins_src0_use = 0; ins_src0_tag = '0; ins_src0_rdy = 0;
    ins_src1_use = 0; ins_src1_tag = '0; ins_src1_rdy = 0;
    ins_dst_use = 0; ins_dst_tag = '0;
    wake_valid = 0; wake_tag = '0;
    issue_valid = 0; issue_idx = '0;
    sched_valid = 0; sched_seq = '0;
    squash_valid = 0; squash_seq = '0;
  endtask

  task automatic put(input logic [SEQ_W-1:0] s, input logic [CLS_W-1:0] c, input logic ns,
                     input logic u0, input logic [TAG_W-1:0] t0,
                     input logic u1, input logic [TAG_W-1:0] t1,
                     input logic ud, input logic [TAG_W-1:0] td);
    ins_valid = 1; ins_seq = s; ins_cls = c; ins_nonspec = ns;
    ins_src0_use = u0; ins_src0_tag = t0; ins_src0_rdy = 0;
    ins_src1_use = u1; ins_src1_tag = t1; ins_src1_rdy = 0;
    ins_dst_use = ud; ins_dst_tag = td;
  endtask

  task automatic step(input logic [DEPTH-1:0] r, input int f, input logic ov, input string req);
    exp_t e;
    @(posedge clk);
    e.rdy = r; e.fr = CNT_W'(f); e.fu = (f == 0); e.ov = ov; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    #23 rst_n = 1;
    @(negedge clk);
    step(4'b0000, 4, 0, "R2 reset empty");
    // A: seq10, src0 tag3 waits (scoreboard clear after reset)
    put(8'd10, 3'd1, 0, 1, 5'd3, 0, 5'd0, 1, 5'd5);
    step(4'b0000, 3, 0, "R3 R2 source waits on clear bit");
    wake_valid = 1; wake_tag = 5'd3;
    step(4'b0001, 3, 0, "R5 wakeup of tag 3");
    wake_valid = 1; wake_tag = 5'd9;
    step(4'b0001, 3, 0, "R5 wake with no waiter");
    // B: src0 tag3 already set in scoreboard, dst 9 clears it
    put(8'd11, 3'd2, 0, 1, 5'd3, 0, 5'd0, 1, 5'd9);
    step(4'b0011, 2, 0, "R3 scoreboard hit at insert");
    // C: src0 tag9 (cleared by B), src1 tag 20 out of range
    put(8'd12, 3'd3, 0, 1, 5'd9, 1, 5'd20, 0, 5'd0);
    step(4'b0011, 1, 0, "R4 R6 dst clear and out-of-range src");
    // D: src0 tag7 woken in the same cycle
    put(8'd13, 3'd4, 0, 1, 5'd7, 0, 5'd0, 0, 5'd0);
    wake_valid = 1; wake_tag = 5'd7;
    step(4'b1011, 0, 0, "R8 R1 same-cycle wake, full");
    put(8'd30, 3'd5, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0);
    step(4'b1011, 0, 1, "R10 insert while full dropped");
    issue_valid = 1; issue_idx = 2'd0;
    #1;
    n_chk++;
    if (issue_seq !== 8'd10 || issue_cls !== 3'd1) begin
      n_bad++;
      $display("FAIL R8 issue read: seq=%0d cls=%0d expected seq=10 cls=1", issue_seq, issue_cls);
    end
    step(4'b1010, 1, 1, "R1 issue frees slot 0");
    squash_valid = 1; squash_seq = 8'd11;
    step(4'b0010, 3, 1, "R7 squash younger than 11");
    // F: non-speculative, goes to lowest free slot 0
    put(8'd14, 3'd6, 1, 0, 5'd0, 0, 5'd0, 0, 5'd0);
    step(4'b0010, 2, 1, "R9 R8 non-spec held in slot 0");
    wake_valid = 1; wake_tag = 5'd20;
    sched_valid = 1; sched_seq = 8'd15;
    step(4'b0010, 2, 1, "R9 R6 wrong schedule and out-of-range wake ignored");
    sched_valid = 1; sched_seq = 8'd14;
    step(4'b0011, 2, 1, "R9 schedule grants permission");
    // G: waits on tag9; issue slot1 same cycle, G takes slot 2
    issue_valid = 1; issue_idx = 2'd1;
    put(8'd15, 3'd7, 0, 1, 5'd9, 0, 5'd0, 0, 5'd0);
    step(4'b0001, 2, 1, "R1 R8 issue and insert together");
    wake_valid = 1; wake_tag = 5'd9;
    step(4'b0101, 2, 1, "R5 wake tag 9 for slot 2");
    squash_valid = 1; squash_seq = 8'd14;
    step(4'b0001, 3, 1, "R7 equal sequence survives squash");
    step(4'b0001, 3, 1, "R10 overflow stays set");
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule